// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block sits between a host register interface and a CAN protocol engine. It holds three transmit mailboxes. Each mailbox stores one frame in four 32-bit words: identifier, control, and two data words. The host loads an empty mailbox word by word and then raises a transmit request for it. Every mailbox then steps through a four-state lifecycle: empty, pending, scheduled and transmitting. Among the scheduled mailboxes, the one with the lowest identifier is handed to the engine.

The engine handshake is minimal. A one-cycle start pulse comes out together with the index and the frame words of the transmitting mailbox. The engine later returns a one-cycle done pulse, qualified by success, arbitration-lost and bus-error bits. Each mailbox keeps four sticky outcome flags that the host clears by writing ones. The host can abort a mailbox that is still queued. An abort raised during transmission does not cut the frame short.

Top module: `can_txmb_sched`

## Requirements
- R1: After reset every mailbox reads empty, all outcome flags are clear and `eng_start` is low. The state codes on `mb_state`, two bits per mailbox, are empty=0, pending=1, scheduled=2, transmitting=3.
- R2: A host write selects a word with `host_wr_sel` (0 identifier, 1 control, 2 data word 0, 3 data word 1). It lands only while the addressed mailbox is empty and is otherwise ignored. While a mailbox transmits, its four words appear on `eng_id`, `eng_ctrl`, `eng_data0` and `eng_data1`. These outputs are zero when no mailbox transmits.
- R3: A transmit request on an empty mailbox makes it pending on the next cycle. A request on a non-empty mailbox is ignored.
- R4: A pending mailbox that is not aborted becomes scheduled on the following cycle.
- R5: When no mailbox is transmitting, the scheduled mailbox with the smallest identifier becomes transmitting on the next cycle. The comparison uses the low 29 bits of the identifier word, and a tie goes to the lowest mailbox index. In that same cycle `eng_start` pulses high for one cycle and `eng_mb` gives the index.
- R6: At most one mailbox is transmitting at any time. Other scheduled mailboxes wait in the scheduled state.
- R7: On an engine done pulse, the transmitting mailbox returns to empty on the next cycle. Its finished flag is set. The success flag is set only when ok is high and both failure bits are low. The arbitration-lost flag follows `eng_arb_lost` and the error flag follows `eng_err`. A failed mailbox is not retried.
- R8: An abort on a pending or scheduled mailbox returns it to empty on the next cycle and sets only its finished flag. An abort wins over a grant in the same cycle.
- R9: An abort on a transmitting mailbox leaves it transmitting until done. Its flags then reflect the engine's reported outcome.
- R10: Outcome flags stay set until the host writes 1 to the matching clear input. When a flag is set and cleared in the same cycle, the set wins.
- R11: An abort on an empty mailbox changes neither its state nor its flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr_en | input | 1 | Frame word write strobe |
| host_wr_mb | input | 2 | Mailbox index of the write |
| host_wr_sel | input | 2 | Word select: 0 id, 1 ctrl, 2 data0, 3 data1 |
| host_wr_data | input | 32 | Write data |
| host_tx_req | input | 3 | Per-mailbox transmit request |
| host_abort | input | 3 | Per-mailbox abort request |
| host_clr_fin | input | 3 | Write-1 clear of finished flags |
| host_clr_ok | input | 3 | Write-1 clear of success flags |
| host_clr_arb | input | 3 | Write-1 clear of arbitration-lost flags |
| host_clr_err | input | 3 | Write-1 clear of error flags |
| mb_state | output | 6 | Two-bit state code per mailbox, mailbox 0 in the low bits |
| flag_fin | output | 3 | Finished flags |
| flag_ok | output | 3 | Finished-without-error flags |
| flag_arb | output | 3 | Arbitration-lost flags |
| flag_err | output | 3 | Bus-error flags |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_mb | output | 2 | Index of the transmitting mailbox |
| eng_id | output | 32 | Identifier word of the transmitting frame |
| eng_ctrl | output | 32 | Control word of the transmitting frame |
| eng_data0 | output | 32 | First data word |
| eng_data1 | output | 32 | Second data word |
| eng_done | input | 1 | Engine finished the current frame |
| eng_ok | input | 1 | Frame sent successfully |
| eng_arb_lost | input | 1 | Frame lost arbitration |
| eng_err | input | 1 | Bus error detected |

## Verification
The assertions assume that the engine raises `eng_done` only while a mailbox is transmitting, and only as a single-cycle pulse. They also assume that the host keeps every input free of unknown values once reset is released. The stimulus meets this in two ways. It pulses done only after it has seen the engine-facing mailbox in the transmitting state. It drives every request, abort and clear as a one-cycle strobe that it returns to zero on the next cycle.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;

  typedef enum logic [1:0] {
    MB_EMPTY = 2'd0,
    MB_PEND  = 2'd1,
    MB_SCHED = 2'd2,
    MB_XMIT  = 2'd3
  } mb_state_e;

  localparam int NUM_WORDS = 4;
  localparam int W_ID   = 0;
  localparam int W_CTRL = 1;
  localparam int W_D0   = 2;
  localparam int W_D1   = 3;

  localparam int FL_FIN = 0;
  localparam int FL_OK  = 1;
  localparam int FL_ARB = 2;
  localparam int FL_ERR = 3;
  localparam int NUM_FL = 4;

endpackage

// File: rtl/can_txmb_slot.sv
module can_txmb_slot
  import can_txmb_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [1:0]               wr_sel,
  input  logic [REG_W-1:0]         wr_data,
  input  logic                     tx_req,
  input  logic                     abort_req,
  input  logic                     grant,
  input  logic                     eng_done,
  input  logic                     eng_ok,
  input  logic                     eng_arb_lost,
  input  logic                     eng_err,
  input  logic [NUM_FL-1:0]        clr,
  output mb_state_e                state,
  output logic [NUM_WORDS*REG_W-1:0] frame,
  output logic [NUM_FL-1:0]        flags
);

  mb_state_e          st_q, st_d;
  logic [NUM_FL-1:0]  fl_q, fl_set;
  logic [REG_W-1:0]   word_q [NUM_WORDS];

  // next-state and outcome decode
  always_comb begin
    st_d   = st_q;
    fl_set = '0;
    unique case (st_q)
      MB_EMPTY: if (tx_req) st_d = MB_PEND;
      MB_PEND: begin
        if (abort_req) begin
          st_d           = MB_EMPTY;
          fl_set[FL_FIN] = 1'b1;
        end else begin
          st_d = MB_SCHED;
        end
      end
      MB_SCHED: begin
        if (abort_req) begin
          st_d           = MB_EMPTY;
          fl_set[FL_FIN] = 1'b1;
        end else if (grant) begin
          st_d = MB_XMIT;
        end
      end
      MB_XMIT: begin
        if (eng_done) begin
          st_d           = MB_EMPTY;
          fl_set[FL_FIN] = 1'b1;
          fl_set[FL_OK]  = eng_ok & ~eng_arb_lost & ~eng_err;
          fl_set[FL_ARB] = eng_arb_lost;
          fl_set[FL_ERR] = eng_err;
        end
      end
      default: st_d = MB_EMPTY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= MB_EMPTY;
    end else if (st_d != st_q) begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_q <= '0;
    end else if ((|clr) || (|fl_set)) begin
      fl_q <= (fl_q & ~clr) | fl_set;
    end
  end

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    logic word_we;
    assign word_we = wr_en && (st_q == MB_EMPTY) && (wr_sel == 2'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[k] <= '0;
      end else if (word_we) begin
        word_q[k] <= wr_data;
      end
    end
    assign frame[k*REG_W +: REG_W] = word_q[k];
  end

  assign state = st_q;
  assign flags = fl_q;

  AST_LOAD_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != MB_EMPTY) |=> $stable(frame)); // R2
  AST_REQ_TO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MB_EMPTY && tx_req) |=> (st_q == MB_PEND)); // R3
  AST_PEND_TO_SCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MB_PEND && !abort_req) |=> (st_q == MB_SCHED)); // R4
  AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MB_XMIT && eng_done) |=> (st_q == MB_EMPTY && fl_q[FL_FIN])); // R7
  AST_ABORT_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == MB_PEND || st_q == MB_SCHED) && abort_req) |=> (st_q == MB_EMPTY && fl_q[FL_FIN])); // R8
  AST_XMIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MB_XMIT && !eng_done) |=> (st_q == MB_XMIT)); // R9
  AST_FIN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_q[FL_FIN] && !clr[FL_FIN]) |=> fl_q[FL_FIN]); // R10
  AST_EMPTY_ABORT_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MB_EMPTY && abort_req && !tx_req) |=> (st_q == MB_EMPTY && $stable(fl_q))); // R11

endmodule

// File: rtl/can_txmb_arb.sv
module can_txmb_arb #(
  parameter int NUM_MB = 3,
  parameter int ID_W   = 29
) (
  input  logic [NUM_MB-1:0]      ready,
  input  logic [NUM_MB*ID_W-1:0] ids,
  input  logic                   busy,
  output logic [NUM_MB-1:0]      grant
);

  always_comb begin
    logic            found;
    logic [ID_W-1:0] best;
    int              best_i;
    found  = 1'b0;
    best   = '0;
    best_i = 0;
    grant  = '0;
    // strict compare keeps the lowest index on equal identifiers
    for (int i = 0; i < NUM_MB; i++) begin
      if (ready[i] && (!found || ids[i*ID_W +: ID_W] < best)) begin
        found  = 1'b1;
        best   = ids[i*ID_W +: ID_W];
        best_i = i;
      end
    end
    if (found && !busy) grant[best_i] = 1'b1;
  end

endmodule

// File: rtl/can_txmb_sched.sv
module can_txmb_sched
  import can_txmb_pkg::*;
#(
  parameter int NUM_MB = 3,
  parameter int REG_W  = 32,
  parameter int ID_W   = 29,
  localparam int MB_W  = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_wr_en,
  input  logic [MB_W-1:0]       host_wr_mb,
  input  logic [1:0]            host_wr_sel,
  input  logic [REG_W-1:0]      host_wr_data,
  input  logic [NUM_MB-1:0]     host_tx_req,
  input  logic [NUM_MB-1:0]     host_abort,
  input  logic [NUM_MB-1:0]     host_clr_fin,
  input  logic [NUM_MB-1:0]     host_clr_ok,
  input  logic [NUM_MB-1:0]     host_clr_arb,
  input  logic [NUM_MB-1:0]     host_clr_err,
  output logic [2*NUM_MB-1:0]   mb_state,
  output logic [NUM_MB-1:0]     flag_fin,
  output logic [NUM_MB-1:0]     flag_ok,
  output logic [NUM_MB-1:0]     flag_arb,
  output logic [NUM_MB-1:0]     flag_err,
  output logic                  eng_start,
  output logic [MB_W-1:0]       eng_mb,
  output logic [REG_W-1:0]      eng_id,
  output logic [REG_W-1:0]      eng_ctrl,
  output logic [REG_W-1:0]      eng_data0,
  output logic [REG_W-1:0]      eng_data1,
  input  logic                  eng_done,
  input  logic                  eng_ok,
  input  logic                  eng_arb_lost,
  input  logic                  eng_err
);

  localparam int FR_W = NUM_WORDS * REG_W;

  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  mb_state_e              st_a    [NUM_MB];
  logic [FR_W-1:0]        frame_a [NUM_MB];
  logic [NUM_MB-1:0]      ready, grant, xmit_vec;
  logic [NUM_MB*ID_W-1:0] prio_ids;
  logic                   busy;
  logic                   start_q;

  for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
    logic [NUM_FL-1:0] fl;
    can_txmb_slot #(.REG_W(REG_W)) slot_i (
      .clk          (clk),
      .rst_n        (rst_sync_n),
      .wr_en        (host_wr_en && (host_wr_mb == MB_W'(i))),
      .wr_sel       (host_wr_sel),
      .wr_data      (host_wr_data),
      .tx_req       (host_tx_req[i]),
      .abort_req    (host_abort[i]),
      .grant        (grant[i]),
      .eng_done     (eng_done),
      .eng_ok       (eng_ok),
      .eng_arb_lost (eng_arb_lost),
      .eng_err      (eng_err),
      .clr          ({host_clr_err[i], host_clr_arb[i], host_clr_ok[i], host_clr_fin[i]}),
      .state        (st_a[i]),
      .frame        (frame_a[i]),
      .flags        (fl)
    );
    assign mb_state[2*i +: 2]        = st_a[i];
    assign flag_fin[i]               = fl[FL_FIN];
    assign flag_ok[i]                = fl[FL_OK];
    assign flag_arb[i]               = fl[FL_ARB];
    assign flag_err[i]               = fl[FL_ERR];
    assign xmit_vec[i]               = (st_a[i] == MB_XMIT);
    assign ready[i]                  = (st_a[i] == MB_SCHED) && !host_abort[i];
    assign prio_ids[i*ID_W +: ID_W]  = frame_a[i][W_ID*REG_W +: ID_W];
  end

  assign busy = |xmit_vec;

  can_txmb_arb #(.NUM_MB(NUM_MB), .ID_W(ID_W)) arb_i (
    .ready (ready),
    .ids   (prio_ids),
    .busy  (busy),
    .grant (grant)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      start_q <= 1'b0;
    end else begin
      start_q <= |grant;
    end
  end

  assign eng_start = start_q;

  always_comb begin
    eng_mb    = '0;
    eng_id    = '0;
    eng_ctrl  = '0;
    eng_data0 = '0;
    eng_data1 = '0;
    for (int i = 0; i < NUM_MB; i++) begin
      if (xmit_vec[i]) begin
        eng_mb    = MB_W'(i);
        eng_id    = frame_a[i][W_ID*REG_W   +: REG_W];
        eng_ctrl  = frame_a[i][W_CTRL*REG_W +: REG_W];
        eng_data0 = frame_a[i][W_D0*REG_W   +: REG_W];
        eng_data1 = frame_a[i][W_D1*REG_W   +: REG_W];
      end
    end
  end

  AST_ONE_XMIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones(xmit_vec) <= 1); // R6
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    eng_start |=> !eng_start); // R5
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    eng_start |-> busy); // R5

endmodule

// File: tb/can_txmb_sched_tb.sv
module can_txmb_sched_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [1:0]  host_wr_mb = '0;
  logic [1:0]  host_wr_sel = '0;
  logic [31:0] host_wr_data = '0;
  logic [2:0]  host_tx_req = '0, host_abort = '0;
  logic [2:0]  host_clr_fin = '0, host_clr_ok = '0, host_clr_arb = '0, host_clr_err = '0;
  logic        eng_done = 1'b0, eng_ok = 1'b0, eng_arb_lost = 1'b0, eng_err = 1'b0;
  logic [5:0]  mb_state;
  logic [2:0]  flag_fin, flag_ok, flag_arb, flag_err;
  logic        eng_start;
  logic [1:0]  eng_mb;
  logic [31:0] eng_id, eng_ctrl, eng_data0, eng_data1;

  int    n_chk = 0, n_bad = 0;
  bit    cmp_on = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  can_txmb_sched dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_wr_mb(host_wr_mb), .host_wr_sel(host_wr_sel),
    .host_wr_data(host_wr_data), .host_tx_req(host_tx_req), .host_abort(host_abort),
    .host_clr_fin(host_clr_fin), .host_clr_ok(host_clr_ok),
    .host_clr_arb(host_clr_arb), .host_clr_err(host_clr_err),
    .mb_state(mb_state), .flag_fin(flag_fin), .flag_ok(flag_ok),
    .flag_arb(flag_arb), .flag_err(flag_err),
    .eng_start(eng_start), .eng_mb(eng_mb), .eng_id(eng_id), .eng_ctrl(eng_ctrl),
    .eng_data0(eng_data0), .eng_data1(eng_data1),
    .eng_done(eng_done), .eng_ok(eng_ok), .eng_arb_lost(eng_arb_lost), .eng_err(eng_err)
  );

  // behavioural reference model
  int          m_st  [3];
  logic [31:0] m_w   [3][4];
  bit          m_fl  [3][4];   // fin, ok, arb, err
  bit          m_start;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_st[i] = 0;
        for (int k = 0; k < 4; k++) begin m_w[i][k] = 0; m_fl[i][k] = 0; end
      end
      m_start = 0;
    end else begin
      bit busy;
      int win;
      busy = 0;
      win  = -1;
      for (int i = 0; i < 3; i++) if (m_st[i] == 3) busy = 1;
      if (!busy)
        for (int i = 0; i < 3; i++)
          if (m_st[i] == 2 && !host_abort[i])
            if (win < 0 || m_w[i][0][28:0] < m_w[win][0][28:0]) win = i;
      m_start = (win >= 0);
      for (int i = 0; i < 3; i++) begin
        bit s [4];
        bit c [4];
        for (int k = 0; k < 4; k++) s[k] = 0;
        c[0] = host_clr_fin[i]; c[1] = host_clr_ok[i];
        c[2] = host_clr_arb[i]; c[3] = host_clr_err[i];
        case (m_st[i])
          0: begin
            if (host_wr_en && host_wr_mb == 2'(i)) m_w[i][host_wr_sel] = host_wr_data;
            if (host_tx_req[i]) m_st[i] = 1;
          end
          1: if (host_abort[i]) begin m_st[i] = 0; s[0] = 1; end else m_st[i] = 2;
          2: if (host_abort[i]) begin m_st[i] = 0; s[0] = 1; end
             else if (win == i) m_st[i] = 3;
          default: if (eng_done) begin
            m_st[i] = 0; s[0] = 1;
            s[1] = eng_ok && !eng_arb_lost && !eng_err;
            s[2] = eng_arb_lost; s[3] = eng_err;
          end
        endcase
        for (int k = 0; k < 4; k++) m_fl[i][k] = (m_fl[i][k] && !c[k]) || s[k];
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      int bi;
      bi = -1;
      for (int i = 0; i < 3; i++) begin
        if (m_st[i] == 3) bi = i;
        check({phase, " state"}, 32'(mb_state[2*i +: 2]), 32'(m_st[i]));
        check({phase, " fin"}, 32'(flag_fin[i]), 32'(m_fl[i][0]));
        check({phase, " ok"},  32'(flag_ok[i]),  32'(m_fl[i][1]));
        check({phase, " arb"}, 32'(flag_arb[i]), 32'(m_fl[i][2]));
        check({phase, " err"}, 32'(flag_err[i]), 32'(m_fl[i][3]));
      end
      check({phase, " start"}, 32'(eng_start), 32'(m_start));
      if (bi >= 0) begin
        check({phase, " mb"}, 32'(eng_mb), 32'(bi));
        check({phase, " id"}, eng_id, m_w[bi][0]);
        check({phase, " ctrl"}, eng_ctrl, m_w[bi][1]);
        check({phase, " d0"}, eng_data0, m_w[bi][2]);
        check({phase, " d1"}, eng_data1, m_w[bi][3]);
      end else begin
        check({phase, " idle frame"}, eng_id | eng_ctrl | eng_data0 | eng_data1, 32'h0);
      end
    end
  end

  task automatic clk1();
    @(posedge clk); #1;
    host_wr_en = 0; host_tx_req = 0; host_abort = 0;
    host_clr_fin = 0; host_clr_ok = 0; host_clr_arb = 0; host_clr_err = 0;
    eng_done = 0; eng_ok = 0; eng_arb_lost = 0; eng_err = 0;
  endtask

  task automatic wr(int mb, int sel, logic [31:0] d);
    host_wr_en = 1; host_wr_mb = 2'(mb); host_wr_sel = 2'(sel); host_wr_data = d;
    clk1();
  endtask

  task automatic load(int mb, logic [31:0] id);
    wr(mb, 0, id);
    wr(mb, 1, 32'h0000_0008 + id);
    wr(mb, 2, 32'hA500_0000 ^ id);
    wr(mb, 3, 32'h5A00_0000 ^ (id << 4));
  endtask

  task automatic req(logic [2:0] m); host_tx_req = m; clk1(); endtask
  task automatic abrt(logic [2:0] m); host_abort = m; clk1(); endtask
  task automatic done(bit ok, bit arb, bit err);
    eng_done = 1; eng_ok = ok; eng_arb_lost = arb; eng_err = err; clk1();
  endtask
  task automatic clr_all();
    host_clr_fin = 3'b111; host_clr_ok = 3'b111; host_clr_arb = 3'b111; host_clr_err = 3'b111;
    clk1();
  endtask
  function automatic logic [31:0] st(int i);
    return 32'(mb_state[2*i +: 2]);
  endfunction

  initial begin
    repeat (2000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) clk1();
    cmp_on = 1;
    // R1 reset state
    check("R1 state", 32'(mb_state), 32'h0);
    check("R1 flags", 32'({flag_fin, flag_ok, flag_arb, flag_err}), 32'h0);
    check("R1 start", 32'(eng_start), 32'h0);

    // R3 R4 R5 R2 R7 single frame
    phase = "R3";
    load(0, 32'h123);
    req(3'b001);                  check("R3 pending", st(0), 1);
    phase = "R4"; clk1();         check("R4 scheduled", st(0), 2);
    phase = "R5"; clk1();         check("R5 transmit", st(0), 3);
    check("R5 start", 32'(eng_start), 1);
    phase = "R2"; wr(0, 0, 32'h777);
    check("R2 write ignored", eng_id, 32'h123);
    check("R5 start pulse", 32'(eng_start), 0);
    phase = "R7"; done(1, 0, 0);
    check("R7 empty", st(0), 0);
    check("R7 fin ok", 32'({flag_fin[0], flag_ok[0]}), 32'h3);

    // R10 clear
    phase = "R10"; host_clr_fin = 3'b001; host_clr_ok = 3'b001; clk1();
    check("R10 cleared", 32'({flag_fin[0], flag_ok[0]}), 0);

    // R5 R6 priority, ties to lowest index
    phase = "R5";
    load(0, 32'h300); load(1, 32'h200); load(2, 32'h200);
    req(3'b111); clk1(); clk1();
    check("R5 lowest id wins", st(1), 3);
    check("R5 eng_mb", 32'(eng_mb), 1);
    check("R6 mb0 waits", st(0), 2);
    check("R6 mb2 waits", st(2), 2);
    phase = "R3"; req(3'b010);
    check("R3 req on busy ignored", st(1), 3);
    phase = "R7"; done(1, 0, 0); clk1();
    check("R5 tie to lower index", st(2), 3);
    done(0, 1, 0);
    check("R7 arb lost", 32'({flag_fin[2], flag_ok[2], flag_arb[2], flag_err[2]}), 32'b1010);
    clk1();
    check("R7 mb0 sending", st(0), 3);
    done(1, 0, 1);
    check("R7 error", 32'({flag_fin[0], flag_ok[0], flag_arb[0], flag_err[0]}), 32'b1001);

    // R8 R9 aborts
    phase = "R8"; clr_all();
    load(0, 32'h10); req(3'b001); clk1(); clk1();
    load(1, 32'h5); req(3'b010);
    check("R8 pending", st(1), 1);
    abrt(3'b010);
    check("R8 abort pending", st(1), 0);
    check("R8 fin only", 32'({flag_fin[1], flag_ok[1]}), 32'b10);
    req(3'b010); clk1();
    check("R8 sched", st(1), 2);
    abrt(3'b010);
    check("R8 abort sched", st(1), 0);
    phase = "R9"; abrt(3'b001);
    check("R9 keeps sending", st(0), 3);
    clk1();
    check("R9 still sending", st(0), 3);
    done(1, 0, 0);
    check("R9 outcome ok", 32'({flag_fin[0], flag_ok[0]}), 32'b11);
    phase = "R8"; clr_all();
    load(2, 32'h40); req(3'b100); clk1();
    abrt(3'b100);
    check("R8 abort beats grant", st(2), 0);
    clk1();
    check("R8 no start", 32'(eng_start), 0);

    // R11 abort on empty
    phase = "R11"; clr_all();
    abrt(3'b111);
    check("R11 state", 32'(mb_state), 0);
    check("R11 flags", 32'({flag_fin, flag_ok, flag_arb, flag_err}), 0);

    // R10 set wins over clear
    phase = "R10";
    load(1, 32'h77); req(3'b010); clk1(); clk1();
    host_clr_fin = 3'b010; done(1, 0, 0);
    check("R10 set wins", 32'(flag_fin[1]), 1);
    clk1();
    check("R10 sticky", 32'(flag_fin[1]), 1);
    host_clr_fin = 3'b010; clk1();
    check("R10 clear", 32'(flag_fin[1]), 0);

    repeat (3) clk1();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule